// File: doc/BRIEF.md
# Predicated Four-Lane Vector Execution Unit

This block executes already-decoded vector operations across four parallel lanes. Each lane owns a private slice of a small vector register file, so one operation updates all lanes in the same cycle. A compare operation tests one source register for being greater than zero and stores one predicate bit per lane. Any later register write or store can then be limited to lanes whose bit is set, to lanes whose bit is clear, or to no lane at all, or it can run in every lane.

This lets an if/else over a whole vector run as two masked instruction streams with no branch. The "then" path runs under the mask and the "else" path runs under its complement. Memory is modelled as one flat data-in bus and one data-out bus with a word-enable bit per lane. Every accepted operation finishes one clock edge after it is presented: its result is registered and a one-cycle completion pulse is raised.

Top module: `pvec_unit`

## Requirements
- R1: After reset, all vector registers hold zero, `pred_mask` is 0, `mem_wen` is 0 and `done` is 0.
- R2: Opcode 1 (compare) sets `pred_mask[l]` to 1 exactly when lane l of register `src_a_idx`, read as signed, is greater than zero. A value of zero or below gives 0. The compare writes all four lanes whatever `pred_sel` is. No other opcode changes `pred_mask`.
- R3: Opcode 2 (add) writes `src_a + src_b` per lane into `dst_idx`, in DATA_W-bit two's complement with wraparound.
- R4: `pred_sel` picks the active lanes: 0 selects all lanes, 1 selects lanes whose mask bit is 1, 2 selects lanes whose mask bit is 0, and 3 selects no lane. A register write leaves the destination unchanged in every inactive lane.
- R5: Opcode 3 (move) copies `src_a` into `dst_idx` in each active lane.
- R6: Opcode 4 (load) writes lane l's slice `mem_rdata[l*DATA_W +: DATA_W]` into `dst_idx` in each active lane.
- R7: Opcode 5 (store) puts `src_a` on `mem_wdata` (lane l in bits `[l*DATA_W +: DATA_W]`) one cycle later. It raises `mem_wen[l]` for that one cycle only in active lanes. `mem_wen` is 0 in every cycle that does not follow an accepted store.
- R8: Opcodes 0, 6 and 7 change no register, no mask bit and no write enable.
- R9: `done` is high for exactly the cycle after each accepted operation, and it is high in back-to-back cycles when operations arrive back to back. An operation sees the results of the operation just before it.
- R10: With A = {-3,3,5,7} and B = {5,-6,1,2} (lanes 0..3), the sequence compare A, masked add C = A+B, inverse-masked move C = B leaves C = {5,-3,6,9}.
- R11: While `op_valid` is low, the registers, the mask and `mem_wen` keep their state and `done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Decoded operation code |
| pred_sel | input | 2 | Lane qualification mode |
| dst_idx | input | RIDX_W (3) | Destination register index |
| src_a_idx | input | RIDX_W (3) | First source register index |
| src_b_idx | input | RIDX_W (3) | Second source register index |
| mem_rdata | input | LANES*DATA_W (128) | Load data, one word per lane |
| mem_wdata | output | LANES*DATA_W (128) | Store data, one word per lane |
| mem_wen | output | LANES (4) | Per-lane word write enable |
| pred_mask | output | LANES (4) | Current predicate mask |
| done | output | 1 | Completion pulse |

## Verification
The bench builds the unit with its defaults: four lanes, 32-bit words and five registers. At those values the add can cross the signed 32-bit boundary, and the five registers leave room to hold the two if/else operands, the result and a guard register that must stay untouched. With four lanes, a mask with both set and clear bits reaches every predicate mode in a single pattern, so each lane's write enable and destination can be compared against the mask bit by bit.

// File: rtl/pvec_pkg.sv
package pvec_pkg;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_CMPGT = 3'd1,
        OP_ADD   = 3'd2,
        OP_MOVE  = 3'd3,
        OP_LOAD  = 3'd4,
        OP_STORE = 3'd5
    } vop_e;

    typedef enum logic [1:0] {
        PR_ALL  = 2'd0,
        PR_MASK = 2'd1,
        PR_INV  = 2'd2,
        PR_NONE = 2'd3
    } pmode_e;

    function automatic logic writes_reg(input logic [2:0] code);
        return (code == OP_ADD) || (code == OP_MOVE) || (code == OP_LOAD);
    endfunction

endpackage

// File: rtl/pvec_pred.sv
module pvec_pred
    import pvec_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_en,
    input  logic [LANES-1:0] cmp_bits,
    input  logic [1:0]       pred_sel,
    output logic [LANES-1:0] mask,
    output logic [LANES-1:0] active
);

    typedef struct packed {
        logic [LANES-1:0] mask;
    } pred_st_t;

    pred_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmp_en) st_d.mask = cmp_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Lane enables follow the stored mask, not the compare in flight.
    always_comb begin
        unique case (pmode_e'(pred_sel))
            PR_ALL:  active = '1;
            PR_MASK: active = st_q.mask;
            PR_INV:  active = ~st_q.mask;
            default: active = '0;
        endcase
    end

    assign mask = st_q.mask;

    p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |=> $stable(mask));

    p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en |=> (mask == $past(cmp_bits)));

endmodule

// File: rtl/pvec_lane.sv
module pvec_lane
    import pvec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NREGS  = 5,
    parameter int RIDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic              active,
    input  logic [RIDX_W-1:0] dst,
    input  logic [RIDX_W-1:0] src_a,
    input  logic [RIDX_W-1:0] src_b,
    input  logic [DATA_W-1:0] ld_data,
    output logic              gt_zero,
    output logic [DATA_W-1:0] st_data,
    output logic              st_en
);

    typedef struct packed {
        logic [NREGS-1:0][DATA_W-1:0] regs;
        logic [DATA_W-1:0]            st_data;
        logic                         st_en;
    } lane_st_t;

    lane_st_t          st_d, st_q;
    logic [DATA_W-1:0] a_val, b_val, result;
    logic              is_store, do_write;

    // Register reads: an index past the file reads as zero.
    always_comb begin
        a_val = '0;
        b_val = '0;
        for (int r = 0; r < NREGS; r++) begin
            if (src_a == RIDX_W'(r)) a_val = st_q.regs[r];
            if (src_b == RIDX_W'(r)) b_val = st_q.regs[r];
        end
    end

    always_comb begin
        unique case (vop_e'(op_code))
            OP_ADD:  result = a_val + b_val;
            OP_LOAD: result = ld_data;
            default: result = a_val;
        endcase
    end

    assign is_store = op_valid && (op_code == OP_STORE);
    assign do_write = op_valid && active && writes_reg(op_code);
    assign gt_zero  = $signed(a_val) > 0;

    always_comb begin
        st_d       = st_q;
        st_d.st_en = is_store && active;
        if (is_store) st_d.st_data = a_val;
        for (int r = 0; r < NREGS; r++) begin
            if (do_write && (dst == RIDX_W'(r))) st_d.regs[r] = result;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st_data = st_q.st_data;
    assign st_en   = st_q.st_en;

    p_inactive_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !active) |=> $stable(st_q.regs));

    p_store_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_store && active) |=> !st_en);

    p_idle_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(st_q.regs));

endmodule

// File: rtl/pvec_unit.sv
module pvec_unit
    import pvec_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int DATA_W = 32,
    parameter int NREGS  = 5,
    parameter int RIDX_W = (NREGS > 1) ? $clog2(NREGS) : 1,
    localparam int BUS_W = LANES * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [1:0]        pred_sel,
    input  logic [RIDX_W-1:0] dst_idx,
    input  logic [RIDX_W-1:0] src_a_idx,
    input  logic [RIDX_W-1:0] src_b_idx,
    input  logic [BUS_W-1:0]  mem_rdata,
    output logic [BUS_W-1:0]  mem_wdata,
    output logic [LANES-1:0]  mem_wen,
    output logic [LANES-1:0]  pred_mask,
    output logic              done
);

    typedef struct packed {
        logic done;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic [LANES-1:0] lane_gt, lane_act;
    logic             cmp_en;

    assign cmp_en = op_valid && (op_code == OP_CMPGT);

    pvec_pred #(.LANES(LANES)) u_pred (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_en   (cmp_en),
        .cmp_bits (lane_gt),
        .pred_sel (pred_sel),
        .mask     (pred_mask),
        .active   (lane_act)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pvec_lane #(
            .DATA_W (DATA_W),
            .NREGS  (NREGS),
            .RIDX_W (RIDX_W)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .op_valid (op_valid),
            .op_code  (op_code),
            .active   (lane_act[g]),
            .dst      (dst_idx),
            .src_a    (src_a_idx),
            .src_b    (src_b_idx),
            .ld_data  (mem_rdata[g*DATA_W +: DATA_W]),
            .gt_zero  (lane_gt[g]),
            .st_data  (mem_wdata[g*DATA_W +: DATA_W]),
            .st_en    (mem_wen[g])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = op_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done = st_q.done;

    p_done_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> done);

    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !done);

    p_wen_needs_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && op_code == OP_STORE) |=> (mem_wen == '0));

    p_wen_implies_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wen != '0) |-> done);

endmodule

// File: tb/pvec_unit_test.sv
`timescale 1ns/1ps
module pvec_unit_test;

    localparam int LANES  = 4;
    localparam int DATA_W = 32;
    localparam int NREGS  = 5;
    localparam int RIDX_W = 3;
    localparam int BUS_W  = LANES * DATA_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              op_valid = 1'b0;
    logic [2:0]        op_code = '0;
    logic [1:0]        pred_sel = '0;
    logic [RIDX_W-1:0] dst_idx = '0, src_a_idx = '0, src_b_idx = '0;
    logic [BUS_W-1:0]  mem_rdata = '0;
    logic [BUS_W-1:0]  mem_wdata;
    logic [LANES-1:0]  mem_wen;
    logic [LANES-1:0]  pred_mask;
    logic              done;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    pvec_unit #(.LANES(LANES), .DATA_W(DATA_W), .NREGS(NREGS), .RIDX_W(RIDX_W)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .pred_sel(pred_sel), .dst_idx(dst_idx), .src_a_idx(src_a_idx),
        .src_b_idx(src_b_idx), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
        .mem_wen(mem_wen), .pred_mask(pred_mask), .done(done)
    );

    function automatic logic [BUS_W-1:0] vec(input int l0, l1, l2, l3);
        return {l3[31:0], l2[31:0], l1[31:0], l0[31:0]};
    endfunction

    task automatic chk(input string req, input logic [BUS_W-1:0] act, exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [1:0] ps,
                         input int d, a, b);
        op_code = op; pred_sel = ps;
        dst_idx = RIDX_W'(d); src_a_idx = RIDX_W'(a); src_b_idx = RIDX_W'(b);
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic load_vec(input int d, input logic [BUS_W-1:0] v);
        mem_rdata = v;
        issue(3'd4, 2'd0, d, 0, 0);
    endtask

    task automatic read_reg(input int r, output logic [BUS_W-1:0] v);
        issue(3'd5, 2'd0, 0, r, 0);
        v = mem_wdata;
    endtask

    task automatic t_reset();
        logic [BUS_W-1:0] v;
        chk("R1 done", BUS_W'(done), '0);
        chk("R1 wen", BUS_W'(mem_wen), '0);
        chk("R1 mask", BUS_W'(pred_mask), '0);
        for (int r = 0; r < NREGS; r++) begin
            read_reg(r, v);
            chk("R1 reg zero", v, '0);
        end
    endtask

    task automatic t_add_wrap();
        logic [BUS_W-1:0] v;
        load_vec(0, vec(32'h7fffffff, 1, -1, 5));
        load_vec(1, vec(1, 1, 1, -10));
        read_reg(0, v);
        chk("R6 load", v, vec(32'h7fffffff, 1, -1, 5));
        issue(3'd2, 2'd0, 2, 0, 1);
        read_reg(2, v);
        chk("R3 add wrap", v, vec(32'h80000000, 2, 0, -5));
    endtask

    task automatic t_compare();
        load_vec(0, vec(-3, 3, 0, 7));
        issue(3'd1, 2'd2, 0, 0, 0);
        chk("R2 compare mask", BUS_W'(pred_mask), BUS_W'(4'b1010));
        issue(3'd2, 2'd0, 4, 0, 0);
        chk("R2 mask kept by add", BUS_W'(pred_mask), BUS_W'(4'b1010));
    endtask

    task automatic t_ifelse();
        logic [BUS_W-1:0] v;
        load_vec(0, vec(-3, 3, 5, 7));
        load_vec(1, vec(5, -6, 1, 2));
        issue(3'd1, 2'd0, 0, 0, 0);
        chk("R10 mask", BUS_W'(pred_mask), BUS_W'(4'b1110));
        issue(3'd2, 2'd1, 2, 0, 1);
        issue(3'd3, 2'd2, 2, 1, 0);
        read_reg(2, v);
        chk("R10 if/else result", v, vec(5, -3, 6, 9));
    endtask

    task automatic t_masked_keep();
        logic [BUS_W-1:0] v;
        load_vec(3, vec(11, 22, 33, 44));
        issue(3'd3, 2'd3, 3, 0, 0);
        read_reg(3, v);
        chk("R4 no-lane mode keeps dst", v, vec(11, 22, 33, 44));
        issue(3'd3, 2'd1, 3, 1, 0);
        read_reg(3, v);
        chk("R5 masked move", v, vec(11, -6, 1, 2));
        mem_rdata = vec(100, 200, 300, 400);
        issue(3'd4, 2'd2, 3, 0, 0);
        read_reg(3, v);
        chk("R4 inverse-masked load", v, vec(100, -6, 1, 2));
    endtask

    task automatic t_store();
        issue(3'd5, 2'd1, 0, 0, 0);
        chk("R7 masked wen", BUS_W'(mem_wen), BUS_W'(4'b1110));
        chk("R7 wdata", mem_wdata, vec(-3, 3, 5, 7));
        chk("R9 done after store", BUS_W'(done), BUS_W'(1'b1));
        issue(3'd5, 2'd2, 0, 1, 0);
        chk("R7 inverse wen", BUS_W'(mem_wen), BUS_W'(4'b0001));
        chk("R7 wdata b", mem_wdata, vec(5, -6, 1, 2));
        issue(3'd5, 2'd3, 0, 1, 0);
        chk("R7 no-lane store wen", BUS_W'(mem_wen), '0);
        idle();
        chk("R7 wen drops", BUS_W'(mem_wen), '0);
        chk("R9 done single pulse", BUS_W'(done), '0);
    endtask

    task automatic t_nop_idle();
        logic [BUS_W-1:0] v;
        issue(3'd6, 2'd0, 0, 1, 1);
        chk("R8 op6 no wen", BUS_W'(mem_wen), '0);
        chk("R8 op6 mask", BUS_W'(pred_mask), BUS_W'(4'b1110));
        issue(3'd7, 2'd0, 0, 1, 1);
        issue(3'd0, 2'd0, 0, 1, 1);
        read_reg(0, v);
        chk("R8 reserved ops keep reg", v, vec(-3, 3, 5, 7));
        op_code = 3'd2; pred_sel = 2'd0;
        dst_idx = 3'd0; src_a_idx = 3'd1; src_b_idx = 3'd1;
        mem_rdata = '0;
        idle();
        chk("R11 no done when idle", BUS_W'(done), '0);
        op_code = 3'd1; src_a_idx = 3'd4;
        idle();
        chk("R11 mask kept when idle", BUS_W'(pred_mask), BUS_W'(4'b1110));
        read_reg(0, v);
        chk("R11 reg kept when idle", v, vec(-3, 3, 5, 7));
    endtask

    task automatic t_chain();
        logic [BUS_W-1:0] v;
        issue(3'd2, 2'd0, 4, 0, 1);
        chk("R9 done b2b 1", BUS_W'(done), BUS_W'(1'b1));
        issue(3'd3, 2'd0, 3, 4, 0);
        chk("R9 done b2b 2", BUS_W'(done), BUS_W'(1'b1));
        read_reg(3, v);
        chk("R9 forwarded result", v, vec(2, -3, 6, 9));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add_wrap();
        t_compare();
        t_ifelse();
        t_masked_keep();
        t_store();
        t_nop_idle();
        t_chain();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule